// File: doc/BRIEF.md
# Dual-Sequencer Interrupt Status Register

This block is a 16-bit status and flag word shared by two independent conversion sequencers. For each sequencer it takes an end-of-sequence pulse, a busy level, an interrupt-mode select and a sequencer-reset strobe. From these it keeps two bits per sequencer: an end-of-sequence parity bit and an interrupt flag. It drives one interrupt request per sequencer, and that request is the flag itself.

In the default mode every end-of-sequence event raises the flag. In the alternate mode the parity bit flips on each event. The flag is raised only by an event that arrives while the parity bit is already 1, so an interrupt occurs on every second completed sequence. Software acknowledges an interrupt by writing 1 to a one-shot clear bit. The parity bit is not touched by an acknowledge or by a sequencer reset; only the device reset returns it to zero.

The word is read combinationally at any time. A write is a single-cycle enable with a 16-bit data word, and only the two clear bits of that word have any effect.

Top module: `seq_irq_status`

## Requirements
- R1: After the active-low device reset, the read word is 0x0000 and both interrupt outputs are 0.
- R2: Bits 15..8 of the read word are always 0, and writing any value to them changes nothing.
- R3: With the mode select low (mode 0), the sequencer's parity bit reads 0 from the cycle after any clock edge at which the mode is low. Its flag is set on every end-of-sequence pulse.
- R4: With the mode select high (mode 1), the sequencer's parity bit inverts on every end-of-sequence pulse and holds its value otherwise.
- R5: In mode 1, a pulse sets the flag only if the parity bit was 1 before that pulse. Counting from reset, the flag therefore rises on the 2nd, 4th and 6th pulses.
- R6: A write with bit 4 (sequencer 1) or bit 5 (sequencer 2) set clears that sequencer's flag after the next edge. A write with the bit at 0 leaves the flag alone. Bits 5 and 4 always read 0.
- R7: Neither a flag clear nor the sequencer-reset input changes a parity bit.
- R8: Bits 3 and 2 show the busy inputs of sequencer 2 and sequencer 1. Writes to bits 3..0 have no effect.
- R9: When a clear write and a flag-setting pulse reach the same sequencer in the same cycle, the flag ends up set.
- R10: Interrupt output i equals the flag of sequencer i: bit 0 for sequencer 1 and bit 1 for sequencer 2. Bits 7 and 6 hold the parity bits of sequencer 2 and sequencer 1.
- R11: The two sequencers are independent. A pulse, clear or mode setting for one sequencer never alters the other sequencer's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| eos_pulse | input | 2 | End-of-sequence pulse per sequencer (bit 0 = sequencer 1) |
| seq_busy | input | 2 | Busy level per sequencer |
| irq_mode | input | 2 | Interrupt mode per sequencer (1 = every second event) |
| seq_rst | input | 2 | Sequencer reset strobe per sequencer |
| wr_en | input | 1 | Single-cycle write enable |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Status word |
| irq | output | 2 | Interrupt request per sequencer |

## Verification
A software acknowledge and an end-of-sequence event can hit the same flag in the same cycle. The bench provokes this by driving a clear write together with a flag-setting pulse on one edge, in mode 0 and also in mode 1 with the parity bit at 1. It expects the flag to read 1 afterwards. It also places a clear write on the same edge as a pulse that does not set the flag (mode 1, parity 0), and there it expects the flag cleared and the parity bit inverted.

// File: rtl/seq_irq_pkg.sv
package seq_irq_pkg;
    localparam int NUM_SEQ  = 2;
    localparam int REG_W    = 16;
    localparam int FLAG_LSB = 0;
    localparam int BUSY_LSB = FLAG_LSB + NUM_SEQ;
    localparam int CLR_LSB  = BUSY_LSB + NUM_SEQ;
    localparam int BUF_LSB  = CLR_LSB + NUM_SEQ;
    localparam int USED_W   = BUF_LSB + NUM_SEQ;

    typedef struct packed {
        logic eos_buf;
        logic flag;
    } seq_state_t;
endpackage

// File: rtl/seq_flag_unit.sv
module seq_flag_unit
    import seq_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eos,
    input  logic mode,
    input  logic clr_req,
    input  logic seq_rst,
    output logic eos_buf,
    output logic flag
);
    seq_state_t st_d, st_q;
    logic       set_hit;

    always_comb begin
        st_d    = st_q;
        set_hit = eos && (!mode || st_q.eos_buf);
        if (!mode) begin
            st_d.eos_buf = 1'b0;
        end else if (eos) begin
            st_d.eos_buf = ~st_q.eos_buf;
        end
        if (set_hit) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eos_buf = st_q.eos_buf;
    assign flag    = st_q.flag;

    assert_mode0_buf_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> !eos_buf);
    assert_mode0_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && !mode) |=> flag);
    assert_buf_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && mode) |=> (eos_buf != $past(eos_buf)));
    assert_mode1_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && mode && eos_buf) |=> flag);
    assert_mode1_noset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && mode && !eos_buf && !flag) |=> !flag);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(eos && (!mode || eos_buf))) |=> !flag);
    assert_buf_survives_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_req || seq_rst) && mode && !eos) |=> $stable(eos_buf));
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && eos && (!mode || eos_buf)) |=> flag);
endmodule

// File: rtl/seq_status_pack.sv
module seq_status_pack
    import seq_irq_pkg::*;
(
    input  logic [NUM_SEQ-1:0] eos_buf,
    input  logic [NUM_SEQ-1:0] flag,
    input  logic [NUM_SEQ-1:0] busy,
    output logic [REG_W-1:0]   word
);
    always_comb begin
        word                        = '0;
        word[FLAG_LSB +: NUM_SEQ]   = flag;
        word[BUSY_LSB +: NUM_SEQ]   = busy;
        word[BUF_LSB +: NUM_SEQ]    = eos_buf;
    end
endmodule

// File: rtl/seq_irq_status.sv
module seq_irq_status
    import seq_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEQ-1:0] eos_pulse,
    input  logic [NUM_SEQ-1:0] seq_busy,
    input  logic [NUM_SEQ-1:0] irq_mode,
    input  logic [NUM_SEQ-1:0] seq_rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [NUM_SEQ-1:0] irq
);
    logic [NUM_SEQ-1:0] clr_req;
    logic [NUM_SEQ-1:0] buf_bits;
    logic [NUM_SEQ-1:0] flag_bits;

    assign clr_req = wr_en ? wr_data[CLR_LSB +: NUM_SEQ] : '0;

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        seq_flag_unit u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .eos     (eos_pulse[g]),
            .mode    (irq_mode[g]),
            .clr_req (clr_req[g]),
            .seq_rst (seq_rst[g]),
            .eos_buf (buf_bits[g]),
            .flag    (flag_bits[g])
        );
    end

    seq_status_pack u_pack (
        .eos_buf (buf_bits),
        .flag    (flag_bits),
        .busy    (seq_busy),
        .word    (rd_data)
    );

    assign irq = flag_bits;

    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CLR_LSB +: NUM_SEQ] == '0 && eos_pulse == '0)
        |=> (rd_data[FLAG_LSB +: NUM_SEQ] == $past(rd_data[FLAG_LSB +: NUM_SEQ])));
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[REG_W-1:USED_W] == '0));
endmodule

// File: tb/seq_irq_status_tb.sv
module seq_irq_status_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  eos_pulse = '0;
    logic [1:0]  seq_busy = '0;
    logic [1:0]  irq_mode = '0;
    logic [1:0]  seq_rst = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  irq;

    seq_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .eos_pulse(eos_pulse), .seq_busy(seq_busy),
        .irq_mode(irq_mode), .seq_rst(seq_rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] exp_rd_q[$];
    logic [1:0]  exp_irq_q[$];
    string       tag_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [1:0]  m_buf = '0;
    logic [1:0]  m_flg = '0;

    task automatic step(input logic [1:0] eos, input logic [1:0] mode,
                        input logic [1:0] busy, input logic [1:0] srst,
                        input logic we, input logic [15:0] wd, input string tag);
        logic [1:0] nb;
        logic [1:0] nf;
        @(negedge clk);
        eos_pulse = eos; irq_mode = mode; seq_busy = busy;
        seq_rst = srst; wr_en = we; wr_data = wd;
        for (int i = 0; i < 2; i++) begin
            logic clr;
            logic set;
            clr = we && wd[4+i];
            set = eos[i] && (!mode[i] || m_buf[i]);
            nb[i] = !mode[i] ? 1'b0 : (eos[i] ? ~m_buf[i] : m_buf[i]);
            nf[i] = set ? 1'b1 : (clr ? 1'b0 : m_flg[i]);
        end
        m_buf = nb;
        m_flg = nf;
        exp_rd_q.push_back({8'h00, nb[1], nb[0], 2'b00, busy, nf});
        exp_irq_q.push_back(nf);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_rd_q.size() > 0) begin
                logic [15:0] er;
                logic [1:0]  ei;
                string       t;
                er = exp_rd_q.pop_front();
                ei = exp_irq_q.pop_front();
                t  = tag_q.pop_front();
                n_vec++;
                if (rd_data !== er) begin
                    n_bad++;
                    $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, er);
                end
                if (irq !== ei) begin
                    n_bad++;
                    $display("FAIL %s/R10 irq actual=%b expected=%b", t, irq, ei);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (rd_data !== 16'h0000 || irq !== 2'b00) begin
            n_bad++;
            $display("FAIL R1 in-reset actual=%h/%b expected=0000/00", rd_data, irq);
        end
        @(negedge clk); rst_n = 1'b1;
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0000, "R1");
        // R2 / R8: writes to reserved and read-only bits do nothing
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 16'hFFCF, "R2");
        step(2'b00, 2'b00, 2'b01, 2'b00, 1'b0, 16'h0000, "R8");
        step(2'b00, 2'b00, 2'b10, 2'b00, 1'b1, 16'h000F, "R8");
        step(2'b00, 2'b00, 2'b11, 2'b00, 1'b0, 16'h0000, "R8");
        // R3: mode 0 sets the flag each pulse, parity stays 0
        step(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0000, "R3");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 16'h0000, "R6");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 16'h0010, "R6");
        step(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0000, "R3");
        step(2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0000, "R11");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 16'h0020, "R11");
        // R9: clear and set together in mode 0
        step(2'b01, 2'b00, 2'b00, 2'b00, 1'b1, 16'h0010, "R9");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 16'h0030, "R6");
        // R4 / R5: mode 1 on sequencer 2, flag on 2nd and 4th pulse
        step(2'b10, 2'b10, 2'b00, 2'b00, 1'b0, 16'h0000, "R5");
        step(2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 16'h0000, "R4");
        step(2'b10, 2'b10, 2'b00, 2'b00, 1'b0, 16'h0000, "R5");
        step(2'b00, 2'b10, 2'b00, 2'b00, 1'b1, 16'h0020, "R6");
        step(2'b10, 2'b10, 2'b00, 2'b00, 1'b0, 16'h0000, "R5");
        // R7: clear and sequencer reset keep parity at 1
        step(2'b00, 2'b10, 2'b00, 2'b11, 1'b1, 16'h0030, "R7");
        step(2'b00, 2'b10, 2'b00, 2'b10, 1'b0, 16'h0000, "R7");
        // R9 in mode 1: parity 1, pulse with clear
        step(2'b10, 2'b10, 2'b00, 2'b00, 1'b1, 16'h0020, "R9");
        // clear with a non-setting pulse (parity 0): flag cleared, parity flips
        step(2'b10, 2'b10, 2'b00, 2'b00, 1'b1, 16'h0020, "R5");
        // R11: both in mode 1, sequencer 1 pulses only
        step(2'b01, 2'b11, 2'b01, 2'b00, 1'b0, 16'h0000, "R11");
        step(2'b01, 2'b11, 2'b01, 2'b00, 1'b0, 16'h0000, "R5");
        step(2'b11, 2'b11, 2'b11, 2'b00, 1'b0, 16'h0000, "R4");
        // R3: back to mode 0 zeroes parity
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0000, "R3");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 16'h0030, "R6");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0000, "R10");
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule